// File: doc/BRIEF.md
# Token-Ring Dual-Clock FIFO

This block carries data words from one synchronous clock domain to another, where the two clocks are unrelated. Storage is a circular chain of identical cells. Two positions are tracked without binary or Gray counters. A single write token travels around the ring in the writer's clock domain and marks the cell that takes the next word. A single read token travels in the reader's clock domain and marks the cell that supplies the next word. Each token moves one cell forward on each accepted transfer.

Each cell holds one word and two toggle bits, one owned by each domain. A cell is occupied when its two bits differ. Each domain sees the other domain's toggle bits through a two-flop synchronizer. From that delayed copy, each side forms a conservative flow-control flag. The writer sees full when the token's cell or the cell after it looks occupied. The reader sees empty when the token's cell or the cell after it looks free. As a result, at most DEPTH-1 words are held, and the last remaining word stays in the ring until another word arrives behind it.

A writer raises its request and may keep it high. A write takes place on a put-clock edge only while the full output is low. A reader does the same against the empty output, and it takes the word shown on the output bus at the edge where the read is accepted.

Top module: `tok_cdc_fifo`

## Requirements
- R1: After reset, full_o is 0 and empty_o is 1, and both tokens sit in cell 0.
- R2: valid_o is held at constant 1.
- R3: Every accepted word is delivered exactly once, in the order it was written. A write is accepted when put_req_i=1 and full_o=0 at a put-clock rising edge. A read is accepted when get_req_i=1 and empty_o=0 at a get-clock rising edge.
- R4: A write request while full_o=1 has no effect: its word never appears at the output and the write token does not move.
- R5: A read request while empty_o=1 has no effect: no word is consumed and the read token does not move.
- R6: With the reader idle from reset, full_o rises right after the put-clock edge of the (DEPTH-1)th accepted write and not earlier. It falls again once reads have been seen through the synchronizer.
- R7: empty_o stays 1 while only one unread word is held. The reader therefore drains a full ring to exactly one remaining word.
- R8: Each token stays one-hot and wraps from cell DEPTH-1 back to cell 0 over any number of laps, so long random runs lose no words.
- R9: Once two unread words are held, empty_o falls within three get-clock rising edges after the write that made them visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| put_clk_i | input | 1 | Writer clock |
| get_clk_i | input | 1 | Reader clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| put_req_i | input | 1 | Write request |
| put_data_i | input | WIDTH | Word to write |
| full_o | output | 1 | Ring full; writes are refused |
| get_req_i | input | 1 | Read request |
| get_data_o | output | WIDTH | Word under the read token |
| valid_o | output | 1 | Constant 1 |
| empty_o | output | 1 | Ring empty from the reader's view; reads are refused |

## Verification
Writer-side results come with no delay. full_o reflects an accepted write at the same put edge, so the bench evaluates acceptance at each falling put edge, when full_o already holds the value it will have at the next rising edge. The reader's view of a new word comes two to three get edges after the write. The bench therefore waits six get cycles before it checks that empty_o has fallen, and it samples get_data_o and empty_o only on falling get edges, where both are settled. A long run with unrelated periods and random requests compares every read against an arithmetic sequence, then checks that exactly one word is left behind.

// File: rtl/tok_fifo_pkg.sv
package tok_fifo_pkg;
  localparam int unsigned MIN_DEPTH = 4;

  function automatic int ring_next(input int idx, input int depth);
    return (idx + 1) % depth;
  endfunction

  function automatic int ring_prev(input int idx, input int depth);
    return (idx + depth - 1) % depth;
  endfunction
endpackage

// File: rtl/tok_fifo_cell.sv
module tok_fifo_cell #(
  parameter int unsigned WIDTH = 8,
  parameter bit          HOME  = 1'b0
) (
  input  logic             put_clk_i,
  input  logic             get_clk_i,
  input  logic             rst_ni,
  input  logic             put_en_i,
  input  logic             get_en_i,
  input  logic             ptok_i,
  input  logic             gtok_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             ptok_o,
  output logic             gtok_o,
  output logic [WIDTH-1:0] data_o,
  output logic             put_tgl_o,
  output logic             get_tgl_o
);
  // put domain: token, word, write toggle
  always_ff @(posedge put_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptok_o    <= HOME;
      put_tgl_o <= 1'b0;
      data_o    <= '0;
    end else if (put_en_i) begin
      ptok_o <= ptok_i;
      if (ptok_o) begin
        put_tgl_o <= ~put_tgl_o;
        data_o    <= data_i;
      end
    end
  end

  // get domain: token, read toggle
  always_ff @(posedge get_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gtok_o    <= HOME;
      get_tgl_o <= 1'b0;
    end else if (get_en_i) begin
      gtok_o <= gtok_i;
      if (gtok_o) get_tgl_o <= ~get_tgl_o;
    end
  end
endmodule

// File: rtl/tok_fifo_sync.sv
module tok_fifo_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta <= '0;
      q_o  <= '0;
    end else begin
      meta <= d_i;
      q_o  <= meta;
    end
  end
endmodule

// File: rtl/tok_fifo_flag.sv
module tok_fifo_flag #(
  parameter int unsigned DEPTH     = 8,
  parameter bit          WATCH_FREE = 1'b0
) (
  input  logic [DEPTH-1:0] tok_i,
  input  logic [DEPTH-1:0] occ_i,
  output logic             flag_o
);
  logic [DEPTH-1:0] sel, sel_next;

  generate
    if (WATCH_FREE) begin : g_free
      assign sel = ~occ_i;
    end else begin : g_busy
      assign sel = occ_i;
    end
    for (genvar i = 0; i < DEPTH; i++) begin : g_rot
      localparam int NXT = tok_fifo_pkg::ring_next(i, DEPTH);
      assign sel_next[i] = sel[NXT];
    end
  endgenerate

  // token cell or the one after it
  assign flag_o = |(tok_i & (sel | sel_next));
endmodule

// File: rtl/tok_cdc_fifo.sv
module tok_cdc_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 8
) (
  input  logic             put_clk_i,
  input  logic             get_clk_i,
  input  logic             rst_ni,
  input  logic             put_req_i,
  input  logic [WIDTH-1:0] put_data_i,
  output logic             full_o,
  input  logic             get_req_i,
  output logic [WIDTH-1:0] get_data_o,
  output logic             valid_o,
  output logic             empty_o
);
  logic [DEPTH-1:0] ptok, gtok, put_tgl, get_tgl;
  logic [DEPTH-1:0] get_tgl_ps, put_tgl_gs;
  logic [DEPTH-1:0] occ_put, occ_get;
  logic [WIDTH-1:0] cell_data [DEPTH];
  logic             put_en, get_en;

  assign put_en = put_req_i & ~full_o;
  assign get_en = get_req_i & ~empty_o;

  generate
    if (DEPTH < tok_fifo_pkg::MIN_DEPTH) begin : g_bad_depth
      initial $error("tok_cdc_fifo: DEPTH below minimum");
    end
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      localparam int PRV = tok_fifo_pkg::ring_prev(i, DEPTH);
      tok_fifo_cell #(.WIDTH(WIDTH), .HOME(i == 0)) u_cell (
        .put_clk_i (put_clk_i),
        .get_clk_i (get_clk_i),
        .rst_ni    (rst_ni),
        .put_en_i  (put_en),
        .get_en_i  (get_en),
        .ptok_i    (ptok[PRV]),
        .gtok_i    (gtok[PRV]),
        .data_i    (put_data_i),
        .ptok_o    (ptok[i]),
        .gtok_o    (gtok[i]),
        .data_o    (cell_data[i]),
        .put_tgl_o (put_tgl[i]),
        .get_tgl_o (get_tgl[i])
      );
    end
  endgenerate

  tok_fifo_sync #(.W(DEPTH)) u_sync_to_put (
    .clk_i (put_clk_i), .rst_ni(rst_ni), .d_i(get_tgl), .q_o(get_tgl_ps)
  );
  tok_fifo_sync #(.W(DEPTH)) u_sync_to_get (
    .clk_i (get_clk_i), .rst_ni(rst_ni), .d_i(put_tgl), .q_o(put_tgl_gs)
  );

  assign occ_put = put_tgl ^ get_tgl_ps;
  assign occ_get = put_tgl_gs ^ get_tgl;

  tok_fifo_flag #(.DEPTH(DEPTH), .WATCH_FREE(1'b0)) u_full (
    .tok_i(ptok), .occ_i(occ_put), .flag_o(full_o)
  );
  tok_fifo_flag #(.DEPTH(DEPTH), .WATCH_FREE(1'b1)) u_empty (
    .tok_i(gtok), .occ_i(occ_get), .flag_o(empty_o)
  );

  always_comb begin
    get_data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      get_data_o = get_data_o | (cell_data[i] & {WIDTH{gtok[i]}});
    end
  end

  assign valid_o = 1'b1;
endmodule

// File: rtl/tok_cdc_fifo_chk.sv
module tok_cdc_fifo_chk #(
  parameter int unsigned DEPTH = 8
) (
  input logic             put_clk_i,
  input logic             get_clk_i,
  input logic             rst_ni,
  input logic             put_req_i,
  input logic             get_req_i,
  input logic             full_o,
  input logic             empty_o,
  input logic             valid_o,
  input logic [DEPTH-1:0] ptok,
  input logic [DEPTH-1:0] gtok
);
  AST_PTOK_ONEHOT: assert property (@(posedge put_clk_i) disable iff (!rst_ni)
    $onehot(ptok)); // R8
  AST_GTOK_ONEHOT: assert property (@(posedge get_clk_i) disable iff (!rst_ni)
    $onehot(gtok)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge put_clk_i) disable iff (!rst_ni)
    (put_req_i && full_o) |=> $stable(ptok)); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge get_clk_i) disable iff (!rst_ni)
    (get_req_i && empty_o) |=> $stable(gtok)); // R5
  AST_PTOK_STEP: assert property (@(posedge put_clk_i) disable iff (!rst_ni)
    (put_req_i && !full_o) |=> ptok == {$past(ptok[DEPTH-2:0]), $past(ptok[DEPTH-1])}); // R3
  AST_GTOK_STEP: assert property (@(posedge get_clk_i) disable iff (!rst_ni)
    (get_req_i && !empty_o) |=> gtok == {$past(gtok[DEPTH-2:0]), $past(gtok[DEPTH-1])}); // R3
  AST_VALID_HIGH: assert property (@(posedge get_clk_i) disable iff (!rst_ni)
    valid_o); // R2
endmodule

bind tok_cdc_fifo tok_cdc_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .put_clk_i (put_clk_i),
  .get_clk_i (get_clk_i),
  .rst_ni    (rst_ni),
  .put_req_i (put_req_i),
  .get_req_i (get_req_i),
  .full_o    (full_o),
  .empty_o   (empty_o),
  .valid_o   (valid_o),
  .ptok      (ptok),
  .gtok      (gtok)
);

// File: tb/tb_tok_cdc_fifo.sv
`timescale 1ns/1ps
module tb_tok_cdc_fifo;
  localparam int DEPTH = 8;
  localparam int WIDTH = 8;

  logic put_clk = 1'b0, get_clk = 1'b0, rst_ni = 1'b0;
  logic put_req = 1'b0, get_req = 1'b0;
  logic [WIDTH-1:0] put_data = '0;
  logic [WIDTH-1:0] get_data;
  logic full, empty, valid;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  int wnext, rexp;

  always #5    put_clk = ~put_clk;   // 100 MHz
  always #6.5  get_clk = ~get_clk;   // unrelated period

  tok_cdc_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .put_clk_i(put_clk), .get_clk_i(get_clk), .rst_ni(rst_ni),
    .put_req_i(put_req), .put_data_i(put_data), .full_o(full),
    .get_req_i(get_req), .get_data_o(get_data), .valid_o(valid),
    .empty_o(empty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    int n, rd;
    repeat (3) @(negedge put_clk);
    rst_ni = 1'b1;
    @(negedge put_clk);
    chk(full == 1'b0, "R1 full after reset", full, 0);
    chk(empty == 1'b1, "R1 empty after reset", empty, 1);
    chk(valid == 1'b1, "R2 valid", valid, 1);

    // fill with reader idle; extra requests while full must vanish (R4)
    n = 0;
    for (int i = 0; i < 10; i++) begin
      put_req  = 1'b1;
      put_data = WIDTH'(i);
      if (!full) n++;
      @(negedge put_clk);
    end
    put_req = 1'b0;
    chk(n == DEPTH - 1, "R6 accepted writes until full", n, DEPTH - 1);
    chk(full == 1'b1, "R6 full held", full, 1);

    // drain: every word but the last, in order; rest of loop hits empty (R5)
    repeat (4) @(negedge get_clk);
    rd = 0;
    for (int i = 0; i < 30; i++) begin
      get_req = 1'b1;
      if (!empty) begin
        chk(get_data == WIDTH'(rd), "R3 drain order", get_data, rd);
        rd++;
      end
      @(negedge get_clk);
    end
    get_req = 1'b0;
    chk(rd == DEPTH - 2, "R7 one word held back", rd, DEPTH - 2);
    chk(empty == 1'b1, "R7 empty with one word", empty, 1);
    chk(valid == 1'b1, "R2 valid", valid, 1);
    repeat (4) @(negedge put_clk);
    chk(full == 1'b0, "R6 full released", full, 0);

    // one more word makes the held word visible (R9); nothing was lost (R5)
    put_req  = 1'b1;
    put_data = 8'd7;
    @(negedge put_clk);
    put_req = 1'b0;
    repeat (6) @(negedge get_clk);
    chk(empty == 1'b0, "R9 empty falls after second word", empty, 0);
    get_req = 1'b1;
    chk(get_data == 8'd6, "R5 held word next", get_data, 6);
    @(negedge get_clk);
    get_req = 1'b0;
    chk(empty == 1'b1, "R7 empty again", empty, 1);

    // long random run over many ring laps (R8, R3)
    wnext = 8;
    rexp  = 7;
    fork
      begin
        for (int i = 0; i < 3000; i++) begin
          put_req  = ($urandom % 3) != 0;
          put_data = WIDTH'(wnext);
          if (put_req && !full) wnext++;
          @(negedge put_clk);
        end
        put_req = 1'b0;
      end
      begin
        for (int i = 0; i < 2700; i++) begin
          get_req = (i >= 2600) || (($urandom % 2) != 0);
          if (get_req && !empty) begin
            chk(get_data == WIDTH'(rexp), "R3 random order", get_data, rexp & 8'hff);
            rexp++;
          end
          @(negedge get_clk);
        end
        get_req = 1'b0;
      end
    join
    chk(rexp == wnext - 1, "R8 all but one delivered", rexp, wnext - 1);
    chk(wnext - 8 > 5 * DEPTH, "R8 ring wrapped many laps", wnext - 8, 5 * DEPTH);
    chk(empty == 1'b1, "R7 final empty", empty, 1);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      summary();
      $finish;
    end
  end
endmodule